// File: doc/BRIEF.md
# Cascaded Edge-Triggered Interrupt Controller

Two eight-input interrupt controllers joined as a PC/AT style cascade. Fifteen request lines enter the block. The block raises one interrupt line toward the processor. When the processor acknowledges, the block answers with an 8-bit vector. The secondary controller's interrupt output feeds input 2 of the primary controller. When the primary controller selects that input during an acknowledge, the vector comes from the secondary controller.

Requests are edge triggered. A rising request is remembered. That remembered request reaches the interrupt output only while the line is still high, so a request that drops before its acknowledge is never serviced. Within each controller, input 0 has the highest priority and input 7 the lowest. An in-service register blocks requests of equal or lower priority until software writes an end-of-interrupt command. Each controller has a small register port (select, address bit, read and write strobes) for its vector base and its mask.

Top module: `irq_cascade`

## Requirements
- R1: After reset `int_o` is 0, both masks read back as 00h, the primary vector base is 08h and the secondary vector base is 70h.
- R2: One rising edge gives exactly one service. A line held high after its acknowledge and end-of-interrupt does not assert `int_o` again.
- R3: A request whose line falls before the acknowledge is not serviced. `int_o` falls with it, and an acknowledge with no live request returns base with low bits 111.
- R4: Within a controller the lowest-numbered live, unmasked input wins. The vector is the base with bits [2:0] replaced by that input's number.
- R5: When primary input 2 (the secondary's output) wins, the vector comes from the secondary's base and its winning input. The primary in-service bit 2 is set, which blocks primary inputs 3..7 until end-of-interrupt.
- R6: A write with `a0_i`=1 outside an initialization sequence sets the mask. A masked input never asserts `int_o`. The mask reads back with `a0_i`=1.
- R7: A write with `a0_i`=0 and bit 4 set starts initialization. The next `a0_i`=1 write loads the vector base with bits [2:0] forced to 0 and leaves the mask unchanged.
- R8: A write with `a0_i`=0, bit 5 set and bit 4 clear is an end-of-interrupt. It clears the highest-priority in-service bit. A higher-priority request can still interrupt while a lower one is in service.
- R9: `irq_i[2]` has no effect, because primary input 2 is driven by the cascade.
- R10: `vec_vld_o` pulses for exactly the one cycle after a cycle with `inta_i` high. `vec_o` holds the vector during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | Request lines: [7:0] primary, [15:8] secondary; bit 2 unused |
| cs_m_i | input | 1 | Register select, primary controller |
| cs_s_i | input | 1 | Register select, secondary controller |
| a0_i | input | 1 | Register address bit |
| wr_i | input | 1 | Register write strobe, one cycle |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data: a0=1 mask, a0=0 live pending requests |
| inta_i | input | 1 | Interrupt acknowledge, one-cycle pulse |
| int_o | output | 1 | Interrupt request to processor |
| vec_o | output | 8 | Acknowledge vector |
| vec_vld_o | output | 1 | Vector valid, one cycle after acknowledge |

## Verification
The bench builds the block with its default eight inputs per controller and the reset bases 08h and 70h. It sweeps every usable request line through raise, acknowledge, end-of-interrupt and release, first with the reset bases and then after reprogramming them to 50h and 58h. Every vector in both base sets is therefore compared with base-plus-index arithmetic. The small size also makes it possible to cover these cases directly: priority pairs, masking of each line, a request that drops before its acknowledge, nesting of a higher request over a lower one in service, and blocking through the cascade input.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int VEC_W = 8;

  // index of the lowest set bit (highest priority); 0 when empty
  function automatic logic [2:0] lowest_set(input logic [7:0] v);
    logic [2:0] r;
    r = 3'd0;
    for (int k = 7; k >= 0; k--) begin
      if (v[k]) r = 3'(k);
    end
    return r;
  endfunction

  // inputs still allowed to interrupt given the in-service set
  function automatic logic [7:0] allow_below(input logic [7:0] isr);
    if (isr == 8'h00) return 8'hFF;
    return (8'h01 << lowest_set(isr)) - 8'h01;
  endfunction

  function automatic logic [7:0] mk_vec(input logic [7:0] base, input logic [2:0] idx);
    return {base[7:3], idx};
  endfunction

endpackage

// File: rtl/irqc_unit.sv
module irqc_unit
  import irqc_pkg::*;
#(
  parameter int          N        = 8,
  parameter logic [7:0]  BASE_RST = 8'h08,
  parameter logic [N-1:0] LEVEL_IN = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     line_i,
  input  logic             wr_i,
  input  logic             a0_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic             ack_i,
  output logic             int_o,
  output logic [7:0]       vec_o,
  output logic             sel_vld_o,
  output logic [$clog2(N)-1:0] sel_o,
  output logic [7:0]       base_o
);

  localparam int IW = $clog2(N);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] prev_q, pend_q, mask_q, isr_q;
  logic [7:0]   base_q;
  logic         init_wait_q;

  logic [N-1:0] rise, eff, cand, live, ack_hit, eoi_clr;
  logic [7:0]   live8, isr8, eff8, mask8, allow8;
  logic [2:0]   isr_lo, sel3;
  logic         isr_any, eoi_wr, init_wr, base_wr, mask_wr;

  always_comb begin
    rise    = line_i & ~prev_q & ~LEVEL_IN;
    eff     = (pend_q & line_i) | (line_i & LEVEL_IN);
    cand    = eff & ~mask_q;
    isr8    = '0;
    isr8[N-1:0] = isr_q;
    isr_any = |isr_q;
    isr_lo  = lowest_set(isr8);
    allow8  = allow_below(isr8);
    live    = cand & allow8[N-1:0];
    live8   = '0;
    live8[N-1:0] = live;
    sel3    = lowest_set(live8);
    eff8    = '0;
    eff8[N-1:0] = eff;
    mask8   = '0;
    mask8[N-1:0] = mask_q;
  end

  assign sel_vld_o = |live;
  assign sel_o     = sel3[IW-1:0];
  assign int_o     = sel_vld_o;
  assign vec_o     = sel_vld_o ? mk_vec(base_q, sel3) : mk_vec(base_q, 3'd7);
  assign base_o    = base_q;
  assign rdata_o   = a0_i ? mask8 : eff8;

  assign ack_hit = (ack_i && sel_vld_o) ? (ONE << sel_o) : '0;
  assign eoi_wr  = wr_i && !a0_i && wdata_i[5] && !wdata_i[4];
  assign init_wr = wr_i && !a0_i && wdata_i[4];
  assign base_wr = wr_i && a0_i && init_wait_q;
  assign mask_wr = wr_i && a0_i && !init_wait_q;
  assign eoi_clr = (eoi_wr && isr_any) ? (ONE << isr_lo[IW-1:0]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= '0;
      pend_q      <= '0;
      mask_q      <= '0;
      isr_q       <= '0;
      base_q      <= BASE_RST;
      init_wait_q <= 1'b0;
    end else begin
      prev_q <= line_i;
      pend_q <= (pend_q | rise) & line_i & ~ack_hit & ~LEVEL_IN;
      isr_q  <= (isr_q & ~eoi_clr) | ack_hit;
      if (init_wr) init_wait_q <= 1'b1;
      else if (base_wr) init_wait_q <= 1'b0;
      if (base_wr) base_q <= {wdata_i[7:3], 3'b000};
      if (mask_wr) mask_q <= wdata_i[N-1:0];
    end
  end

  // R6: interrupt only with some unmasked line high
  a_r6_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> |(line_i & ~mask_q));
  // R2: a serviced edge request is consumed
  a_r2_ack_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && sel_vld_o) |=> ((pend_q & $past(ack_hit) & ~LEVEL_IN) == '0));
  // R8: acknowledge marks the input in service
  a_r8_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && sel_vld_o && !eoi_wr) |=> ((isr_q & $past(ack_hit)) != '0));
  // R8: a selected input outranks everything in service
  a_r8_isr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vld_o && isr_any) |-> (sel3 < isr_lo));
  // R7: base low bits always clear
  a_r7_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[2:0] == 3'b000);

endmodule

// File: rtl/irq_cascade.sv
module irq_cascade
  import irqc_pkg::*;
#(
  parameter int         N         = 8,
  parameter int         CASC_IDX  = 2,
  parameter logic [7:0] M_BASE    = 8'h08,
  parameter logic [7:0] S_BASE    = 8'h70
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*N-1:0]     irq_i,
  input  logic               cs_m_i,
  input  logic               cs_s_i,
  input  logic               a0_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic               inta_i,
  output logic               int_o,
  output logic [7:0]         vec_o,
  output logic               vec_vld_o
);

  localparam int IW = $clog2(N);
  localparam logic [N-1:0] LVL = {{(N-1){1'b0}}, 1'b1} << CASC_IDX;

  logic [N-1:0]  m_line, s_line;
  logic          s_int, m_int, m_vld, s_vld, s_ack, casc_hit;
  logic [IW-1:0] m_sel, s_sel;
  logic [7:0]    m_vec, s_vec, m_rd, s_rd, m_base, s_base, vec_d;
  logic [7:0]    vec_q;
  logic          vld_q;
  logic          unused_casc_line;

  assign unused_casc_line = irq_i[CASC_IDX];
  assign s_line = irq_i[2*N-1:N];

  always_comb begin
    m_line = irq_i[N-1:0];
    m_line[CASC_IDX] = s_int;
  end

  assign casc_hit = m_vld && (m_sel == IW'(CASC_IDX));
  assign s_ack    = inta_i && casc_hit;
  assign vec_d    = casc_hit ? s_vec : m_vec;

  irqc_unit #(.N(N), .BASE_RST(M_BASE), .LEVEL_IN(LVL)) u_master (
    .clk(clk), .rst_n(rst_n), .line_i(m_line),
    .wr_i(wr_i && cs_m_i), .a0_i(a0_i), .wdata_i(wdata_i), .rdata_o(m_rd),
    .ack_i(inta_i), .int_o(m_int), .vec_o(m_vec), .sel_vld_o(m_vld),
    .sel_o(m_sel), .base_o(m_base)
  );

  irqc_unit #(.N(N), .BASE_RST(S_BASE), .LEVEL_IN('0)) u_slave (
    .clk(clk), .rst_n(rst_n), .line_i(s_line),
    .wr_i(wr_i && cs_s_i), .a0_i(a0_i), .wdata_i(wdata_i), .rdata_o(s_rd),
    .ack_i(s_ack), .int_o(s_int), .vec_o(s_vec), .sel_vld_o(s_vld),
    .sel_o(s_sel), .base_o(s_base)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= inta_i;
      if (inta_i) vec_q <= vec_d;
    end
  end

  assign int_o     = m_int;
  assign vec_o     = vec_q;
  assign vec_vld_o = vld_q;
  assign rdata_o   = !rd_i ? 8'h00 : cs_m_i ? m_rd : cs_s_i ? s_rd : 8'h00;

  // R10: valid strobe follows acknowledge by one cycle
  a_r10_vld_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    inta_i |=> vec_vld_o);
  a_r10_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_i |=> !vec_vld_o);
  // R5: cascade acknowledge takes the secondary base
  a_r5_slave_base: assert property (@(posedge clk) disable iff (!rst_n)
    s_ack |=> (vec_o[7:3] == s_base[7:3]));
  // R5: cascade selection implies the secondary has a request
  a_r5_casc_has_src: assert property (@(posedge clk) disable iff (!rst_n)
    casc_hit |-> s_vld);
  // R4: a primary acknowledge takes the primary base
  a_r4_master_base: assert property (@(posedge clk) disable iff (!rst_n)
    (inta_i && !casc_hit) |=> (vec_o[7:3] == m_base[7:3]));

endmodule

// File: tb/irq_cascade_tb.sv
module irq_cascade_tb;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [15:0] irq = '0;
  logic cs_m = 0, cs_s = 0, a0 = 0, wr = 0, rd = 0, inta = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, vec;
  logic intr, vld;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_cascade u_dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .cs_m_i(cs_m), .cs_s_i(cs_s),
    .a0_i(a0), .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .inta_i(inta), .int_o(intr), .vec_o(vec), .vec_vld_o(vld)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input bit slv, input bit addr, input logic [7:0] d);
    @(negedge clk);
    cs_m = !slv; cs_s = slv; a0 = addr; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0; cs_m = 0; cs_s = 0;
  endtask

  task automatic rd_reg(input bit slv, input bit addr, output logic [7:0] d);
    @(negedge clk);
    cs_m = !slv; cs_s = slv; a0 = addr; rd = 1;
    #1 d = rdata;
    rd = 0; cs_m = 0; cs_s = 0;
  endtask

  task automatic set_line(input int k, input bit v);
    @(negedge clk);
    irq[k] = v;
    @(negedge clk);
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk);
    inta = 1;
    @(negedge clk);
    inta = 0;
    chk("R10 vld", {7'd0, vld}, 8'd1);
    v = vec;
    @(negedge clk);
    chk("R10 vld drop", {7'd0, vld}, 8'd0);
  endtask

  task automatic eoi(input bit slv);
    wr_reg(slv, 0, 8'h20);
  endtask

  task automatic sweep(input logic [7:0] mb, input logic [7:0] sb);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      if (i != 2) begin
        set_line(i, 1);
        chk("R4 int", {7'd0, intr}, 8'd1);
        do_ack(v);
        chk("R4 master vector", v, {mb[7:3], 3'(i)});
        eoi(0);
        chk("R2 no retrigger", {7'd0, intr}, 8'd0);
        set_line(i, 0);
      end
    end
    for (int j = 0; j < 8; j++) begin
      set_line(8 + j, 1);
      chk("R5 int", {7'd0, intr}, 8'd1);
      do_ack(v);
      chk("R5 slave vector", v, {sb[7:3], 3'(j)});
      eoi(1);
      eoi(0);
      chk("R2 no retrigger casc", {7'd0, intr}, 8'd0);
      set_line(8 + j, 0);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 int", {7'd0, intr}, 8'd0);
    rd_reg(0, 1, v); chk("R1 master mask", v, 8'h00);
    rd_reg(1, 1, v); chk("R1 slave mask", v, 8'h00);
    set_line(0, 1); do_ack(v); chk("R1 master base", v, 8'h08); eoi(0); set_line(0, 0);
    set_line(8, 1); do_ack(v); chk("R1 slave base", v, 8'h70); eoi(1); eoi(0); set_line(8, 0);

    sweep(8'h08, 8'h70);

    // R9 bit 2 ignored
    set_line(2, 1);
    chk("R9 int", {7'd0, intr}, 8'd0);
    set_line(2, 0);

    // R4 priority pairs
    for (int a = 0; a < 8; a++) begin
      for (int b = a + 1; b < 8; b++) begin
        if (a != 2 && b != 2) begin
          @(negedge clk); irq[a] = 1; irq[b] = 1;
          @(negedge clk);
          do_ack(v);
          chk("R4 priority", v, {5'b00001, 3'(a)});
          eoi(0);
          do_ack(v);
          chk("R4 second", v, {5'b00001, 3'(b)});
          eoi(0);
          @(negedge clk); irq[a] = 0; irq[b] = 0;
        end
      end
    end

    // R3 drop before ack
    set_line(4, 1);
    set_line(4, 0);
    chk("R3 int drop", {7'd0, intr}, 8'd0);
    do_ack(v);
    chk("R3 spurious", v, 8'h0F);
    set_line(5, 1);
    chk("R3 no isr left", {7'd0, intr}, 8'd1);
    do_ack(v); eoi(0); set_line(5, 0);

    // R6 masking every line
    for (int i = 0; i < 8; i++) begin
      if (i != 2) begin
        wr_reg(0, 1, 8'(1 << i));
        rd_reg(0, 1, v); chk("R6 mask readback", v, 8'(1 << i));
        set_line(i, 1);
        chk("R6 masked", {7'd0, intr}, 8'd0);
        set_line(i, 0);
      end
    end
    wr_reg(0, 1, 8'h00);
    wr_reg(1, 1, 8'h20);
    set_line(13, 1);
    chk("R6 slave masked", {7'd0, intr}, 8'd0);
    set_line(13, 0);
    wr_reg(1, 1, 8'h00);

    // R8 nesting
    set_line(4, 1); do_ack(v); chk("R8 first", v, 8'h0C);
    set_line(6, 1);
    chk("R8 lower blocked", {7'd0, intr}, 8'd0);
    set_line(1, 1);
    chk("R8 higher passes", {7'd0, intr}, 8'd1);
    do_ack(v); chk("R8 nested vec", v, 8'h09);
    eoi(0);
    chk("R8 still blocked", {7'd0, intr}, 8'd0);
    eoi(0);
    chk("R8 released", {7'd0, intr}, 8'd1);
    do_ack(v); chk("R8 low vec", v, 8'h0E);
    eoi(0);
    @(negedge clk); irq[1] = 0; irq[4] = 0; irq[6] = 0;

    // R5 cascade in service blocks 3..7 but not 0
    set_line(9, 1); do_ack(v); chk("R5 casc vec", v, 8'h71);
    set_line(3, 1);
    chk("R5 blocks lower", {7'd0, intr}, 8'd0);
    set_line(0, 1);
    chk("R5 higher passes", {7'd0, intr}, 8'd1);
    do_ack(v); chk("R5 higher vec", v, 8'h08);
    eoi(0); eoi(1); eoi(0);
    chk("R5 lower released", {7'd0, intr}, 8'd1);
    do_ack(v); chk("R5 lower vec", v, 8'h0B);
    eoi(0);
    @(negedge clk); irq[0] = 0; irq[3] = 0; irq[9] = 0;

    // R7 reprogram bases, mask kept
    wr_reg(0, 1, 8'h40);
    wr_reg(0, 0, 8'h11); wr_reg(0, 1, 8'h53);
    rd_reg(0, 1, v); chk("R7 mask kept", v, 8'h40);
    wr_reg(0, 1, 8'h00);
    wr_reg(1, 0, 8'h11); wr_reg(1, 1, 8'h5F);
    sweep(8'h50, 8'h58);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule